// File: doc/BRIEF.md
# Pipelined Odd-Even Transposition Sorter

This block sorts a vector of N unsigned samples in a fixed number of clock cycles. The N lanes arrive in parallel on one flat input bus. They leave in ascending order on a flat output bus of the same shape, so the smallest value sits in the bottom lane and the largest in the top lane.

The sorter is a chain of N register stages. Each stage holds compare-exchange cells on alternating lane pairs, and a plain delay register on any lane left unpaired in that stage. Every stage therefore costs exactly one clock, and the time through the block never depends on the data. A new vector may be offered on every clock. A valid flag travels beside the data, and there is no backpressure. A median picker or a windowed image filter can sit directly on the output lanes.

Top module: `sortnet_top`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it is released, `out_valid` is low; vectors offered during reset never appear as valid.
- R2: `out_valid` is high exactly N rising edges after `in_valid` was sampled high, and low otherwise; the delay is the same for every data value.
- R3: When `out_valid` is high, lane i of `out_data` (bits `[i*W+W-1 : i*W]`) is less than or equal to lane i+1 under unsigned comparison, so lane 0 holds the minimum and lane N-1 the maximum.
- R4: When `out_valid` is high, the output lanes hold the same multiset of values as the input vector that entered N cycles earlier.
- R5: A vector accepted on every consecutive clock is sorted independently of its neighbours, giving one sorted vector per clock.
- R6: An input whose lanes are all equal, or that contains ties, comes out with the tied values intact and no other value introduced.
- R7: An ascending input (lane 0 smallest) passes through unchanged, and a descending input is fully reversed.
- R8: Data offered while `in_valid` is low never reaches a valid output, and the pattern of gaps between valid vectors is kept at the output.
- R9: The block works with N = 5 and N = 9, and in both cases its latency equals N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | The input vector on `in_data` is to be sorted |
| in_data | input | N*W | N unsigned lanes, lane i at bits `[i*W+W-1 : i*W]` |
| out_valid | output | 1 | `out_data` holds a sorted vector |
| out_data | output | N*W | Sorted lanes, ascending from lane 0 to lane N-1 |

## Verification
A five-lane, three-bit instance is driven with every one of its 32768 possible input vectors back to back. This covers all tie patterns and all orderings at that size, and shows that one vector per clock never disturbs its neighbour. A nine-lane, eight-bit instance receives all-equal, binary-valued, ascending and descending vectors, followed by random vectors. The descending vector needs every stage to swap, so it exposes a missing or misplaced stage. Random valid gaps with junk data on idle cycles separate a correct valid pipeline from one that is off by a cycle or that leaks idle data.

// File: rtl/sortnet_pkg.sv
package sortnet_pkg;

  // A stage of phase P pairs lanes (P,P+1), (P+2,P+3), ...
  // Returns 1 when `lane` is the lower member of such a pair.
  function automatic bit pair_base(input int lane, input int phase, input int n);
    return (lane >= phase) && (((lane - phase) % 2) == 0) && (lane + 1 < n);
  endfunction

  // Phase of stage s: even stages start at lane 0, odd stages at lane 1.
  function automatic int stage_phase(input int s);
    return s % 2;
  endfunction

endpackage

// File: rtl/sortnet_cmpx.sv
// Registered compare-exchange cell: the smaller value goes to the lower lane.
// Equal values are passed straight through.
module sortnet_cmpx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);

  always_ff @(posedge clk) begin
    if (hi_i < lo_i) begin
      lo_o <= hi_i;
      hi_o <= lo_i;
    end else begin
      lo_o <= lo_i;
      hi_o <= hi_i;
    end
  end

endmodule

// File: rtl/sortnet_dly.sv
// One-cycle delay for a lane that has no partner in its stage.
module sortnet_dly #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    q_o <= d_i;
  end

endmodule

// File: rtl/sortnet_stage.sv
// One stage of the network: compare-exchange on lane pairs chosen by
// PHASE, and a delay register on each lane left unpaired.
module sortnet_stage #(
  parameter int N     = 9,
  parameter int W     = 8,
  parameter int PHASE = 0
) (
  input  logic           clk,
  input  logic [N*W-1:0] d_i,
  output logic [N*W-1:0] d_o
);

  for (genvar i = 0; i < N; i++) begin : g_lane
    if (sortnet_pkg::pair_base(i, PHASE, N)) begin : g_cx
      sortnet_cmpx #(.W(W)) cx_i (
        .clk  (clk),
        .lo_i (d_i[i*W +: W]),
        .hi_i (d_i[(i+1)*W +: W]),
        .lo_o (d_o[i*W +: W]),
        .hi_o (d_o[(i+1)*W +: W])
      );
    end else if (!sortnet_pkg::pair_base(i - 1, PHASE, N)) begin : g_pass
      sortnet_dly #(.W(W)) dly_i (
        .clk (clk),
        .d_i (d_i[i*W +: W]),
        .q_o (d_o[i*W +: W])
      );
    end
  end

endmodule

// File: rtl/sortnet_top.sv
// N-lane odd-even transposition sorter, one registered stage per clock.
module sortnet_top #(
  parameter int N = 9,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  output logic [N*W-1:0] out_data
);

  localparam int NW = N * W;

  logic [NW-1:0] bus [N+1];
  logic [N-1:0]  vpipe;

  assign bus[0] = in_data;

  for (genvar s = 0; s < N; s++) begin : g_stage
    sortnet_stage #(
      .N     (N),
      .W     (W),
      .PHASE (sortnet_pkg::stage_phase(s))
    ) stage_i (
      .clk (clk),
      .d_i (bus[s]),
      .d_o (bus[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
    end else begin
      vpipe <= {vpipe[N-2:0], in_valid};
    end
  end

  assign out_valid = vpipe[N-1];
  assign out_data  = bus[N];

endmodule

// File: rtl/sortnet_chk.sv
// Property checker bound to sortnet_top.
module sortnet_chk #(
  parameter int N = 9,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N*W-1:0] in_data,
  input logic           out_valid,
  input logic [N*W-1:0] out_data
);

  localparam int SW = W + $clog2(N) + 1;

  logic [N-1:0]  sh_v;
  logic [SW-1:0] sh_sum [N];
  logic [SW-1:0] in_sum, out_sum;
  logic          ordered;

  always_comb begin
    in_sum  = '0;
    out_sum = '0;
    ordered = 1'b1;
    for (int i = 0; i < N; i++) begin
      in_sum  = in_sum  + SW'(in_data[i*W +: W]);
      out_sum = out_sum + SW'(out_data[i*W +: W]);
    end
    for (int i = 0; i < N - 1; i++) begin
      if (out_data[i*W +: W] > out_data[(i+1)*W +: W]) ordered = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sh_v <= '0;
    else     sh_v <= {sh_v[N-2:0], in_valid};
    sh_sum[0] <= in_sum;
    for (int i = 1; i < N; i++) sh_sum[i] <= sh_sum[i-1];
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == sh_v[N-1]);

  p_order_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ordered);

  p_sum_kept_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum == sh_sum[N-1]));

endmodule

bind sortnet_top sortnet_chk #(.N(N), .W(W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sortnet_tb_core.sv
// Drives one sorter instance and checks every output cycle.
module sortnet_tb_core #(
  parameter int N     = 5,
  parameter int W     = 3,
  parameter int RANDS = 200
) (
  input  logic clk,
  output logic done,
  output int   checks,
  output int   errors
);

  localparam int NW = N * W;

  logic          rst, in_valid, out_valid;
  logic [NW-1:0] in_data, out_data;

  sortnet_top #(.N(N), .W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  logic          sv [64];
  logic [NW-1:0] sd [64];
  string         st [64];
  int            cyc;

  function automatic logic [NW-1:0] ref_sort(input logic [NW-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [NW-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    for (int i = 1; i < N; i++) begin
      for (int j = i; j > 0; j--) begin
        if (a[j] < a[j-1]) begin
          t = a[j]; a[j] = a[j-1]; a[j-1] = t;
        end
      end
    end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  function automatic logic [NW-1:0] rand_vec();
    logic [NW-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom);
    return r;
  endfunction

  // Sample outputs, then drive the next input, all on the falling edge.
  task automatic step(input logic r, input logic v, input logic [NW-1:0] d,
                      input string tag);
    int idx;
    logic [NW-1:0] exp;
    @(negedge clk);
    cyc++;
    idx = (cyc - N) & 63;
    checks++;
    if (out_valid !== sv[idx]) begin
      errors++;
      $display("FAIL R2 %s N=%0d: out_valid=%b expected %b", st[idx], N,
               out_valid, sv[idx]);
    end
    if (out_valid === 1'b1 && sv[idx]) begin
      exp = ref_sort(sd[idx]);
      checks++;
      if (out_data !== exp) begin
        errors++;
        $display("FAIL %s R3 N=%0d: out_data=%h expected %h", st[idx], N,
                 out_data, exp);
      end
    end
    rst      = r;
    in_valid = v;
    in_data  = d;
    sv[cyc & 63] = v && !r;
    sd[cyc & 63] = d;
    st[cyc & 63] = tag;
  endtask

  initial begin
    logic [NW-1:0] asc, desc;
    done = 1'b0; checks = 0; errors = 0; cyc = 0;
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    for (int i = 0; i < 64; i++) begin sv[i] = 1'b0; sd[i] = '0; st[i] = "R1"; end

    // R1: vectors offered during reset must vanish
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, rand_vec(), "R1");
    step(1'b0, 1'b0, '0, "R1");
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 N=%0d: out_valid=%b expected 0", N, out_valid);
    end

    // R6: all-equal and tie-heavy vectors
    step(1'b0, 1'b1, '0, "R6");
    step(1'b0, 1'b1, '1, "R6");
    step(1'b0, 1'b1, {N{W'(5)}}, "R6");
    for (int k = 0; k < 20; k++) begin
      logic [NW-1:0] b;
      for (int i = 0; i < N; i++) b[i*W +: W] = W'($urandom % 2);
      step(1'b0, 1'b1, b, "R6");
    end

    // R7: ascending passes through, descending reverses
    for (int i = 0; i < N; i++) begin
      asc[i*W +: W]  = W'((i * ((1 << W) - 1)) / (N - 1));
      desc[i*W +: W] = W'(((N - 1 - i) * ((1 << W) - 1)) / (N - 1));
    end
    step(1'b0, 1'b1, asc, "R7");
    step(1'b0, 1'b1, desc, "R7");
    step(1'b0, 1'b1, desc, "R7");

    // R4, R5: exhaustive back-to-back sweep when small, else random
    if (NW <= 15) begin
      for (int k = 0; k < (1 << NW); k++) step(1'b0, 1'b1, NW'(k), "R4");
    end else begin
      for (int k = 0; k < RANDS; k++) step(1'b0, 1'b1, rand_vec(), "R5");
    end

    // R8: random gaps with junk data while idle
    for (int k = 0; k < 400; k++) step(1'b0, 1'($urandom % 2), rand_vec(), "R8");
    for (int k = 0; k < N + 3; k++) step(1'b0, 1'b0, rand_vec(), "R8");
    done = 1'b1;
  end

endmodule

// File: tb/sortnet_top_tb_top.sv
// R9: runs a five-lane and a nine-lane instance side by side.
module sortnet_top_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic d5, d9;
  int   c5, e5, c9, e9;

  sortnet_tb_core #(.N(5), .W(3), .RANDS(200))  core5_i (
    .clk(clk), .done(d5), .checks(c5), .errors(e5));
  sortnet_tb_core #(.N(9), .W(8), .RANDS(3000)) core9_i (
    .clk(clk), .done(d9), .checks(c9), .errors(e9));

  initial begin
    int cycles;
    int wd;
    cycles = 0;
    wd = 0;
    #1;
    while (!(d5 && d9) && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(d5 && d9)) begin
      wd = 1;
      $display("FAIL R9 watchdog: done=%b%b expected 11", d5, d9);
    end
    $display("CHECKS %0d ERRORS %0d", c5 + c9 + wd, e5 + e9 + wd);
    $finish;
  end

endmodule